// File: doc/BRIEF.md
# Sized Load/Store Data Aligner

This block sits between a 24-bit register file and a 32-bit little-endian data bus. It handles one sized transfer per request: 8-bit, 16-bit or 32-bit, in either direction. For a load, it picks the addressed bytes from the read word and extends them into a 24-bit register value. For a store, it moves register bytes onto the right byte lanes and drives the matching byte enables.

On the same request it forms the effective address from a base register value and checks that address for natural alignment. A bad address raises a misalignment interrupt request and cancels the transfer. The block also works out the new base value for post-increment, post-decrement and pre-decrement addressing. By default the step equals the access size. An optional extension immediate replaces that step.

All results are registered, so they appear one clock after the request. The bus read data is sampled in the same cycle as the load request.

Top module: `lsa_top`

## Requirements
- R1: After reset, and in any cycle that follows a cycle without a request, all outputs are zero. `rsp_valid` is high exactly one cycle after each cycle with `req_valid` high.
- R2: A byte load with `req_signed`=0 returns the addressed byte in bits 7–0, with bits 23–8 cleared.
- R3: A byte load with `req_signed`=1 copies bit 7 of the byte into bits 15–8 and clears bits 23–16.
- R4: A 16-bit load returns the byte at the lower address in bits 7–0 and the next byte in bits 15–8, clears bits 23–16, and ignores `req_signed`. A 32-bit load returns bytes 0–2 in bits 23–0 and drops byte 3.
- R5: A byte store puts store bits 7–0 on the addressed lane. A 16-bit store puts bits 15–0 on the two lanes starting at the addressed lane. A 32-bit store puts bits 23–0 on lanes 0–2 and 0x00 on lane 3. Unused lanes carry zero, and `bus_wdata` is zero on loads.
- R6: `bus_be` (bit n = lane n) is 0001 for byte, 0011 for 16-bit or 1111 for 32-bit accesses, shifted left by address bits 1–0, for both loads and stores. It is 0000 when no access takes place.
- R7: `req_size` encodes 0=byte, 1=16-bit, 2 or 3=32-bit. A 16-bit access with effective address bit 0 set, or a 32-bit access with address bits 1–0 not 00, sets `misalign_irq`. It also clears `bus_access`, `bus_we`, `bus_be`, `bus_wdata`, `load_val` and `base_we`.
- R8: `addr_mode` encodes 0=plain, 1=post-increment, 2=post-decrement, 3=pre-decrement. The effective address is base−step for pre-decrement, and the base itself for every other mode. For modes 1–3, `base_we` is set. `base_new` is then base+step for mode 1 and base−step for modes 2 and 3, modulo 2^24.
- R9: The step is 1, 2 or 4 by access size. When `ext_valid` is set, the step is `ext_step` (zero-extended) instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Transfer request this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Access size code |
| req_signed | input | 1 | Sign-extend byte loads |
| addr_mode | input | 2 | Base-register addressing mode |
| base_val | input | 24 | Current base register value |
| ext_valid | input | 1 | Extension immediate supplied |
| ext_step | input | 13 | Extension immediate step |
| store_val | input | 24 | Register value to store |
| bus_rdata | input | 32 | Read word from the data bus |
| rsp_valid | output | 1 | Result of the previous cycle's request |
| bus_addr | output | 24 | Effective address |
| bus_access | output | 1 | Transfer goes ahead |
| bus_we | output | 1 | Transfer is a write |
| bus_be | output | 4 | Byte lane enables |
| bus_wdata | output | 32 | Lane-aligned write data |
| load_val | output | 24 | Extended load result |
| misalign_irq | output | 1 | Misalignment interrupt request |
| base_we | output | 1 | Base register update valid |
| base_new | output | 24 | Updated base value |

## Verification
The assertions assume that `req_valid` is low throughout reset, so the first registered response cannot come from a request made during reset. They also assume that every request input is stable around the clock edge, so that the registered size and direction match the request that produced each response. The bench changes inputs only on the falling edge and holds `req_valid` low during reset. It drops `req_valid` between vectors, so every idle cycle also tests the all-zero response. The size code 3 is left out of the vectors, because it behaves exactly like code 2.

// File: rtl/lsa_pkg.sv
package lsa_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WALT = 2'd3
  } size_e;

  typedef enum logic [1:0] {
    AM_PLAIN   = 2'd0,
    AM_POSTINC = 2'd1,
    AM_POSTDEC = 2'd2,
    AM_PREDEC  = 2'd3
  } amode_e;

  // Bytes moved by one access of the given size.
  function automatic logic [2:0] size_bytes(input size_e sz);
    case (sz)
      SZ_BYTE: size_bytes = 3'd1;
      SZ_HALF: size_bytes = 3'd2;
      default: size_bytes = 3'd4;
    endcase
  endfunction

  // Natural alignment rule on the two low address bits.
  function automatic logic bad_align(input size_e sz, input logic [1:0] lo);
    case (sz)
      SZ_BYTE: bad_align = 1'b0;
      SZ_HALF: bad_align = lo[0];
      default: bad_align = |lo;
    endcase
  endfunction

  function automatic logic is_word(input size_e sz);
    is_word = (sz == SZ_WORD) || (sz == SZ_WALT);
  endfunction
endpackage

// File: rtl/lsa_addr_gen.sv
module lsa_addr_gen
  import lsa_pkg::*;
#(
  parameter int AW = 24,
  parameter int SW = 13
) (
  input  logic [AW-1:0] base_val,
  input  amode_e        mode,
  input  size_e         size,
  input  logic          ext_valid,
  input  logic [SW-1:0] ext_step,
  output logic [AW-1:0] eff_addr,
  output logic          upd_en,
  output logic [AW-1:0] upd_val
);
  logic [AW-1:0] step;
  logic [AW-1:0] dec_val;
  logic [AW-1:0] inc_val;

  always_comb begin
    step    = ext_valid ? AW'(ext_step) : AW'(size_bytes(size));
    dec_val = base_val - step;
    inc_val = base_val + step;
    eff_addr = (mode == AM_PREDEC) ? dec_val : base_val;
    upd_en   = (mode != AM_PLAIN);
    upd_val  = (mode == AM_POSTINC) ? inc_val : dec_val;
  end
endmodule

// File: rtl/lsa_load_fmt.sv
module lsa_load_fmt
  import lsa_pkg::*;
#(
  parameter int RW = 24,
  parameter int BW = 32,
  localparam int LANES = BW / 8,
  localparam int LW = $clog2(LANES)
) (
  input  logic [BW-1:0] rdata,
  input  logic [LW-1:0] lane,
  input  size_e         size,
  input  logic          sgn,
  output logic [RW-1:0] value
);
  logic [BW-1:0] shifted;
  logic [7:0]    byte_v;
  logic [15:0]   byte_ext;

  always_comb begin
    shifted  = rdata >> (8 * lane);
    byte_v   = shifted[7:0];
    byte_ext = sgn ? {{8{byte_v[7]}}, byte_v} : {8'h00, byte_v};
    case (size)
      SZ_BYTE: value = RW'(byte_ext);
      SZ_HALF: value = RW'(shifted[15:0]);
      default: value = rdata[RW-1:0];
    endcase
  end
endmodule

// File: rtl/lsa_store_fmt.sv
module lsa_store_fmt
  import lsa_pkg::*;
#(
  parameter int RW = 24,
  parameter int BW = 32,
  localparam int LANES = BW / 8,
  localparam int LW = $clog2(LANES)
) (
  input  logic [RW-1:0]    sval,
  input  logic [LW-1:0]    lane,
  input  size_e            size,
  output logic [BW-1:0]    wdata,
  output logic [LANES-1:0] be
);
  logic [LANES-1:0] be_base;
  logic [BW-1:0]    data_base;

  always_comb begin
    case (size)
      SZ_BYTE: begin
        be_base   = LANES'(1);
        data_base = BW'(sval[7:0]);
      end
      SZ_HALF: begin
        be_base   = LANES'(3);
        data_base = BW'(sval[15:0]);
      end
      default: begin
        be_base   = '1;
        data_base = BW'(sval);
      end
    endcase
    be    = be_base << lane;
    wdata = data_base << (8 * lane);
  end
endmodule

// File: rtl/lsa_top.sv
module lsa_top
  import lsa_pkg::*;
#(
  parameter int RW = 24,
  parameter int BW = 32,
  parameter int SW = 13,
  localparam int LANES = BW / 8,
  localparam int LW = $clog2(LANES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_store,
  input  logic [1:0]       req_size,
  input  logic             req_signed,
  input  logic [1:0]       addr_mode,
  input  logic [RW-1:0]    base_val,
  input  logic             ext_valid,
  input  logic [SW-1:0]    ext_step,
  input  logic [RW-1:0]    store_val,
  input  logic [BW-1:0]    bus_rdata,
  output logic             rsp_valid,
  output logic [RW-1:0]    bus_addr,
  output logic             bus_access,
  output logic             bus_we,
  output logic [LANES-1:0] bus_be,
  output logic [BW-1:0]    bus_wdata,
  output logic [RW-1:0]    load_val,
  output logic             misalign_irq,
  output logic             base_we,
  output logic [RW-1:0]    base_new
);
  size_e  size_c;
  amode_e mode_c;
  assign size_c = size_e'(req_size);
  assign mode_c = amode_e'(addr_mode);

  logic [RW-1:0]    eff_addr;
  logic             upd_en;
  logic [RW-1:0]    upd_val;
  logic [RW-1:0]    ld_fmt;
  logic [BW-1:0]    st_data;
  logic [LANES-1:0] st_be;

  lsa_addr_gen #(.AW(RW), .SW(SW)) u_addr (
    .base_val (base_val),
    .mode     (mode_c),
    .size     (size_c),
    .ext_valid(ext_valid),
    .ext_step (ext_step),
    .eff_addr (eff_addr),
    .upd_en   (upd_en),
    .upd_val  (upd_val)
  );

  lsa_load_fmt #(.RW(RW), .BW(BW)) u_load (
    .rdata(bus_rdata),
    .lane (eff_addr[LW-1:0]),
    .size (size_c),
    .sgn  (req_signed),
    .value(ld_fmt)
  );

  lsa_store_fmt #(.RW(RW), .BW(BW)) u_store (
    .sval (store_val),
    .lane (eff_addr[LW-1:0]),
    .size (size_c),
    .wdata(st_data),
    .be   (st_be)
  );

  // Named internal events
  logic misalign_ev;
  logic go_ev;
  assign misalign_ev = req_valid && bad_align(size_c, eff_addr[1:0]);
  assign go_ev       = req_valid && !misalign_ev;

  size_e r_size;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      bus_addr     <= '0;
      bus_access   <= 1'b0;
      bus_we       <= 1'b0;
      bus_be       <= '0;
      bus_wdata    <= '0;
      load_val     <= '0;
      misalign_irq <= 1'b0;
      base_we      <= 1'b0;
      base_new     <= '0;
      r_size       <= SZ_BYTE;
    end else begin
      rsp_valid    <= req_valid;
      bus_addr     <= req_valid ? eff_addr : '0;
      bus_access   <= go_ev;
      bus_we       <= go_ev && req_store;
      bus_be       <= go_ev ? st_be : '0;
      bus_wdata    <= (go_ev && req_store) ? st_data : '0;
      load_val     <= (go_ev && !req_store) ? ld_fmt : '0;
      misalign_irq <= misalign_ev;
      base_we      <= go_ev && upd_en;
      base_new     <= (go_ev && upd_en) ? upd_val : '0;
      r_size       <= size_c;
    end
  end

  // Assertions
  assert_rsp_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !bus_access && !misalign_irq && !base_we));
  assert_byte_upper_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_access && !bus_we && r_size == SZ_BYTE) |-> load_val[RW-1:16] == '0);
  assert_load_upper_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_access && !bus_we && r_size == SZ_HALF) |-> load_val[RW-1:16] == '0);
  assert_word_top_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && (&bus_be)) |-> bus_wdata[BW-1:RW] == '0);
  assert_be_shape_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_access |-> ($countones(bus_be) == 1 || $countones(bus_be) == 2 ||
                    $countones(bus_be) == LANES));
  assert_no_be_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_access |-> bus_be == '0);
  assert_misalign_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    misalign_irq |-> (!bus_access && !bus_we && !base_we && bus_be == '0));
  assert_half_aligned_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_access && r_size == SZ_HALF) |-> !bus_addr[0]);
endmodule

// File: tb/tb_lsa_top.sv
module tb_lsa_top;
  localparam int RW = 24;
  localparam int BW = 32;
  localparam int SW = 13;
  localparam logic [31:0] RDATA = 32'hC3B2_A1F0;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n;
  logic          req_valid, req_store, req_signed, ext_valid;
  logic [1:0]    req_size, addr_mode;
  logic [RW-1:0] base_val, store_val;
  logic [SW-1:0] ext_step;
  logic [BW-1:0] bus_rdata;
  logic          rsp_valid, bus_access, bus_we, misalign_irq, base_we;
  logic [RW-1:0] bus_addr, load_val, base_new;
  logic [3:0]    bus_be;
  logic [BW-1:0] bus_wdata;

  lsa_top dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .req_size(req_size), .req_signed(req_signed), .addr_mode(addr_mode),
    .base_val(base_val), .ext_valid(ext_valid), .ext_step(ext_step),
    .store_val(store_val), .bus_rdata(bus_rdata), .rsp_valid(rsp_valid),
    .bus_addr(bus_addr), .bus_access(bus_access), .bus_we(bus_we),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .load_val(load_val),
    .misalign_irq(misalign_irq), .base_we(base_we), .base_new(base_new)
  );

  typedef struct packed {
    logic        st;
    logic [1:0]  sz;
    logic        sg;
    logic [1:0]  md;
    logic [23:0] base;
    logic        xv;
    logic [12:0] xs;
    logic [23:0] sv;
    logic [23:0] e_addr;
    logic [3:0]  e_be;
    logic [31:0] e_wd;
    logic [23:0] e_ld;
    logic        e_mis;
    logic        e_bwe;
    logic [23:0] e_bnew;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    // R2 unsigned byte, lane 1
    '{1'b0, 2'd0, 1'b0, 2'd0, 24'h000101, 1'b0, 13'd0, 24'h0, 24'h000101, 4'b0010, 32'h0, 24'h0000A1, 1'b0, 1'b0, 24'h0},
    // R3 signed byte, post-increment
    '{1'b0, 2'd0, 1'b1, 2'd1, 24'h000101, 1'b0, 13'd0, 24'h0, 24'h000101, 4'b0010, 32'h0, 24'h00FFA1, 1'b0, 1'b1, 24'h000102},
    // R3 signed byte lane 3, post-decrement
    '{1'b0, 2'd0, 1'b1, 2'd2, 24'h000203, 1'b0, 13'd0, 24'h0, 24'h000203, 4'b1000, 32'h0, 24'h00FFC3, 1'b0, 1'b1, 24'h000202},
    // R4 half lane 2, signed flag ignored
    '{1'b0, 2'd1, 1'b1, 2'd0, 24'h000402, 1'b0, 13'd0, 24'h0, 24'h000402, 4'b1100, 32'h0, 24'h00C3B2, 1'b0, 1'b0, 24'h0},
    // R4 word load drops byte 3
    '{1'b0, 2'd2, 1'b0, 2'd1, 24'h000808, 1'b0, 13'd0, 24'h0, 24'h000808, 4'b1111, 32'h0, 24'hB2A1F0, 1'b0, 1'b1, 24'h00080C},
    // R5 word store, pre-decrement R8
    '{1'b1, 2'd2, 1'b0, 2'd3, 24'h000810, 1'b0, 13'd0, 24'h123456, 24'h00080C, 4'b1111, 32'h00123456, 24'h0, 1'b0, 1'b1, 24'h00080C},
    // R5 byte store lane 2
    '{1'b1, 2'd0, 1'b0, 2'd1, 24'h000302, 1'b0, 13'd0, 24'hABCD5A, 24'h000302, 4'b0100, 32'h005A0000, 24'h0, 1'b0, 1'b1, 24'h000303},
    // R5 half store lane 2
    '{1'b1, 2'd1, 1'b0, 2'd0, 24'h000102, 1'b0, 13'd0, 24'h77BEEF, 24'h000102, 4'b1100, 32'hBEEF0000, 24'h0, 1'b0, 1'b0, 24'h0},
    // R7 odd half load
    '{1'b0, 2'd1, 1'b0, 2'd0, 24'h000101, 1'b0, 13'd0, 24'h0, 24'h000101, 4'b0000, 32'h0, 24'h0, 1'b1, 1'b0, 24'h0},
    // R7 word store on lane 2, post-increment suppressed
    '{1'b1, 2'd2, 1'b0, 2'd1, 24'h000102, 1'b0, 13'd0, 24'h111111, 24'h000102, 4'b0000, 32'h0, 24'h0, 1'b1, 1'b0, 24'h0},
    // R7 pre-decrement half lands odd
    '{1'b0, 2'd1, 1'b0, 2'd3, 24'h000201, 1'b0, 13'd0, 24'h0, 24'h0001FF, 4'b0000, 32'h0, 24'h0, 1'b1, 1'b0, 24'h0},
    // R9 extension step on post-increment
    '{1'b0, 2'd0, 1'b0, 2'd1, 24'h000100, 1'b1, 13'h010, 24'h0, 24'h000100, 4'b0001, 32'h0, 24'h0000F0, 1'b0, 1'b1, 24'h000110},
    // R9 extension step on pre-decrement word store
    '{1'b1, 2'd2, 1'b0, 2'd3, 24'h000100, 1'b1, 13'h008, 24'hABCDEF, 24'h0000F8, 4'b1111, 32'h00ABCDEF, 24'h0, 1'b0, 1'b1, 24'h0000F8},
    // R8 post-decrement wraps below zero
    '{1'b0, 2'd0, 1'b0, 2'd2, 24'h000000, 1'b0, 13'd0, 24'h0, 24'h000000, 4'b0001, 32'h0, 24'h0000F0, 1'b0, 1'b1, 24'hFFFFFF},
    // R5 half store lane 0, post-decrement by 2
    '{1'b1, 2'd1, 1'b0, 2'd2, 24'h000300, 1'b0, 13'd0, 24'h128001, 24'h000300, 4'b0011, 32'h00008001, 24'h0, 1'b0, 1'b1, 24'h0002FE},
    // R4 half lane 0 keeps bit 15 without extension
    '{1'b0, 2'd1, 1'b1, 2'd0, 24'h000500, 1'b0, 13'd0, 24'h0, 24'h000500, 4'b0011, 32'h0, 24'h00A1F0, 1'b0, 1'b0, 24'h0}
  };

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    req_valid = 0; req_store = 0; req_size = 0; req_signed = 0;
    addr_mode = 0; base_val = 0; ext_valid = 0; ext_step = 0;
    store_val = 0; bus_rdata = RDATA;
  endtask

  task automatic check_quiet(input string tag);
    check({tag, " rsp_valid"}, 32'(rsp_valid), 0);
    check({tag, " access"}, 32'(bus_access), 0);
    check({tag, " be"}, 32'(bus_be), 0);
    check({tag, " wdata"}, bus_wdata, 0);
    check({tag, " load"}, 32'(load_val), 0);
    check({tag, " irq"}, 32'(misalign_irq), 0);
    check({tag, " base_we"}, 32'(base_we), 0);
    check({tag, " addr"}, 32'(bus_addr), 0);
  endtask

  initial begin
    rst_n = 1'b0;
    idle_inputs();
    repeat (3) @(negedge clk);
    check_quiet("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_quiet("R1 idle after reset");

    foreach (VECS[i]) begin
      req_valid  = 1; req_store = VECS[i].st; req_size = VECS[i].sz;
      req_signed = VECS[i].sg; addr_mode = VECS[i].md; base_val = VECS[i].base;
      ext_valid  = VECS[i].xv; ext_step = VECS[i].xs; store_val = VECS[i].sv;
      @(negedge clk);
      idle_inputs();
      check("R1 rsp_valid", 32'(rsp_valid), 1);
      check("R8 effective address", 32'(bus_addr), 32'(VECS[i].e_addr));
      check("R6 byte enables", 32'(bus_be), 32'(VECS[i].e_be));
      check("R5 write data", bus_wdata, VECS[i].e_wd);
      check("R2 R3 R4 load value", 32'(load_val), 32'(VECS[i].e_ld));
      check("R7 misalign irq", 32'(misalign_irq), 32'(VECS[i].e_mis));
      check("R7 access", 32'(bus_access), 32'(!VECS[i].e_mis));
      check("R5 write strobe", 32'(bus_we), 32'(VECS[i].st && !VECS[i].e_mis));
      check("R8 base write", 32'(base_we), 32'(VECS[i].e_bwe));
      if (VECS[i].e_bwe)
        check("R8 R9 base value", 32'(base_new), 32'(VECS[i].e_bnew));
      @(negedge clk);
      check_quiet("R1 gap");
    end

    // R7: size code 3 behaves as 32-bit (misaligned on lane 1)
    req_valid = 1; req_size = 2'd3; base_val = 24'h000401;
    @(negedge clk);
    idle_inputs();
    check("R7 size code 3 misalign", 32'(misalign_irq), 1);
    @(negedge clk);

    // R1: reset in mid-stream clears a pending response
    req_valid = 1; req_size = 2'd0; base_val = 24'h000010;
    @(negedge clk);
    rst_n = 1'b0;
    idle_inputs();
    #1;
    check_quiet("R1 async reset");
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule